// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block is the fixed control unit of a coprocessor. Each clock it issues one address into a wide microinstruction store. The store is separate from data memory. Its 128-bit words drive the datapath directly, without decoding. The store returns the addressed word one cycle after the address is issued. The sequencer takes two fields of that word: a 4-bit sequence code and a branch target. One cycle later it samples a condition bit from the datapath.

Every instruction passes through four phases: issue, field capture, condition evaluation and commit. The address of an instruction leaves on the commit strobe in its fourth cycle, and a new address is still issued every cycle. A taken sequence redirects the issue address at commit. The three younger addresses already in flight are discarded.

A register-based return stack holds the return addresses for subroutine calls. Two sticky flags report a push into a full stack and a pop from an empty one.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the issue address is 0, the commit strobe is low and both error flags are low. Reset also empties the return stack, so a return committed first after reset underflows.
- R2: While no taken sequence commits, the issue address rises by one each cycle. The address of each instruction is committed, with the strobe high, three cycles after it was issued.
- R3: Code bits [3:2] choose the family: 00 jump, 01 call, 10 return from subroutine, 11 restart. Code bits [1:0] choose the condition: 00 always, 01 never, 10 flag is 1, 11 flag is 0.
- R4: The code and target are sampled one cycle after their address is issued. The condition bit is sampled two cycles after that address is issued.
- R5: In the cycle after a taken sequence commits, the issue address is the redirect address. The next three commit slots have the strobe low, and the discarded instructions change neither the stack nor the issue address.
- R6: A taken call pushes its own address plus one and jumps to the target. A taken return from subroutine pops the most recent entry and continues there. The stack holds 8 entries in last-in, first-out order.
- R7: A taken call into a full stack sets a sticky overflow flag and still jumps to the target. The new entry is dropped and the depth stays at 8.
- R8: A taken return from subroutine on an empty stack sets a sticky underflow flag and is not taken: the issue address goes on by one.
- R9: A taken restart redirects to address 0 and empties the stack.
- R10: A sequence whose condition fails, or whose condition is "never", leaves the stack, the error flags and the issue order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ucode_seq | input | 4 | Sequence code of the word returned for the previous issue address |
| ucode_target | input | AW | Branch target of that same word |
| dp_flag | input | 1 | Datapath condition bit for the address issued two cycles earlier |
| fetch_addr | output | AW | Microinstruction address issued this cycle |
| commit_addr | output | AW | Address of the instruction in its commit phase |
| commit_valid | output | 1 | High when the committing instruction was not discarded |
| stack_ovf | output | 1 | Sticky: a call found the stack full |
| stack_unf | output | 1 | Sticky: a return found the stack empty |

## Verification
The critical coincidence is a taken branch committing while a younger call or return is already in flight. In that cycle the flush has to beat the stack update. The bench places a jump directly ahead of a call and a return, and the jump target returns at once. An underflow with no wrong push, and an unchanged commit stream, shows that the discarded instructions had no effect. The bench also lets a call commit into a full stack: the jump must still be taken and the stack depth must stay at 8.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int SEQ_CODE_W = 4;

  typedef enum logic [1:0] {
    CAT_JUMP    = 2'd0,
    CAT_CALL    = 2'd1,
    CAT_RSUB    = 2'd2,
    CAT_RESTART = 2'd3
  } seq_cat_e;

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'd0,
    CND_NEVER  = 2'd1,
    CND_SET    = 2'd2,
    CND_CLEAR  = 2'd3
  } seq_cond_e;

  function automatic seq_cat_e cat_of(logic [SEQ_CODE_W-1:0] code);
    return seq_cat_e'(code[3:2]);
  endfunction

  function automatic seq_cond_e cond_of(logic [SEQ_CODE_W-1:0] code);
    return seq_cond_e'(code[1:0]);
  endfunction

endpackage

// File: rtl/useq_pipe_stage.sv
module useq_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         kill,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v & ~kill;
      out_d <= in_d;
    end
  end

endmodule

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
  import useq_pkg::*;
(
  input  logic [SEQ_CODE_W-1:0] code,
  input  logic                  flag,
  output logic                  ok
);

  always_comb begin
    unique case (cond_of(code))
      CND_ALWAYS: ok = 1'b1;
      CND_NEVER:  ok = 1'b0;
      CND_SET:    ok = flag;
      CND_CLEAR:  ok = ~flag;
      default:    ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic           clear,
  input  logic [AW-1:0]  push_addr,
  output logic [AW-1:0]  top_addr,
  output logic           empty,
  output logic           ovf,
  output logic           unf,
  output logic [SPW-1:0] sp
);

  logic [DEPTH-1:0][AW-1:0] ent;
  logic                     full;

  assign empty = (sp == '0);
  assign full  = (sp == SPW'(DEPTH));

  always_comb begin
    top_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == SPW'(i + 1)) top_addr = ent[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      ent <= '0;
    end else if (clear) begin
      sp <= '0;
    end else if (push) begin
      if (full) begin
        ovf <= 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (sp == SPW'(i)) ent[i] <= push_addr;
        end
        sp <= sp + 1'b1;
      end
    end else if (pop) begin
      if (empty) unf <= 1'b1;
      else       sp  <= sp - 1'b1;
    end
  end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                  v,
  input  logic [AW-1:0]         addr,
  input  logic [SEQ_CODE_W-1:0] code,
  input  logic [AW-1:0]         target,
  input  logic                  ok,
  input  logic [AW-1:0]         stk_top,
  input  logic                  stk_empty,
  output logic                  redirect,
  output logic [AW-1:0]         redir_addr,
  output logic                  push,
  output logic                  pop,
  output logic                  clear,
  output logic [AW-1:0]         push_addr
);

  logic act;
  assign act       = v & ok;
  assign push_addr = addr + 1'b1;

  always_comb begin
    redirect   = 1'b0;
    redir_addr = target;
    push       = 1'b0;
    pop        = 1'b0;
    clear      = 1'b0;
    unique case (cat_of(code))
      CAT_JUMP: begin
        redirect = act;
      end
      CAT_CALL: begin
        push     = act;
        redirect = act;
      end
      CAT_RSUB: begin
        pop        = act;
        redirect   = act & ~stk_empty;
        redir_addr = stk_top;
      end
      CAT_RESTART: begin
        clear      = act;
        redirect   = act;
        redir_addr = '0;
      end
      default: redirect = 1'b0;
    endcase
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEQ_CODE_W-1:0] ucode_seq,
  input  logic [AW-1:0]         ucode_target,
  input  logic                  dp_flag,
  output logic [AW-1:0]         fetch_addr,
  output logic [AW-1:0]         commit_addr,
  output logic                  commit_valid,
  output logic                  stack_ovf,
  output logic                  stack_unf
);

  localparam int SPW = $clog2(DEPTH + 1);
  localparam int W1  = AW;
  localparam int W2  = AW + SEQ_CODE_W + AW;
  localparam int W3  = W2 + 1;

  logic [AW-1:0]         pc;
  logic                  redirect;
  logic [AW-1:0]         redir_addr;

  logic                  p1_v, p2_v, p3_v;
  logic [W1-1:0]         p1_d;
  logic [W2-1:0]         p2_d;
  logic [W3-1:0]         p3_d;

  logic [AW-1:0]         p2_addr, p3_addr, p2_tgt, p3_tgt;
  logic [SEQ_CODE_W-1:0] p2_code, p3_code;
  logic                  p2_ok, p3_ok;

  logic                  stk_push, stk_pop, stk_clear, stk_empty;
  logic [AW-1:0]         stk_push_addr, stk_top;
  logic [SPW-1:0]        stk_sp;

  // phase 1: issue
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= redirect ? redir_addr : pc + 1'b1;
  end
  assign fetch_addr = pc;

  // phase 2: word returns from the store
  useq_pipe_stage #(.W(W1)) u_p1 (
    .clk(clk), .rst(rst), .kill(redirect),
    .in_v(1'b1), .in_d(pc),
    .out_v(p1_v), .out_d(p1_d)
  );

  // phase 3: condition bit arrives
  useq_pipe_stage #(.W(W2)) u_p2 (
    .clk(clk), .rst(rst), .kill(redirect),
    .in_v(p1_v), .in_d({p1_d, ucode_seq, ucode_target}),
    .out_v(p2_v), .out_d(p2_d)
  );
  assign {p2_addr, p2_code, p2_tgt} = p2_d;

  useq_cond_eval u_cond (
    .code(p2_code), .flag(dp_flag), .ok(p2_ok)
  );

  // phase 4: commit
  useq_pipe_stage #(.W(W3)) u_p3 (
    .clk(clk), .rst(rst), .kill(redirect),
    .in_v(p2_v), .in_d({p2_addr, p2_code, p2_tgt, p2_ok}),
    .out_v(p3_v), .out_d(p3_d)
  );
  assign {p3_addr, p3_code, p3_tgt, p3_ok} = p3_d;

  useq_next_addr #(.AW(AW)) u_next (
    .v(p3_v), .addr(p3_addr), .code(p3_code), .target(p3_tgt),
    .ok(p3_ok), .stk_top(stk_top), .stk_empty(stk_empty),
    .redirect(redirect), .redir_addr(redir_addr),
    .push(stk_push), .pop(stk_pop), .clear(stk_clear),
    .push_addr(stk_push_addr)
  );

  useq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(stk_push), .pop(stk_pop), .clear(stk_clear),
    .push_addr(stk_push_addr), .top_addr(stk_top),
    .empty(stk_empty), .ovf(stack_ovf), .unf(stack_unf), .sp(stk_sp)
  );

  assign commit_addr  = p3_addr;
  assign commit_valid = p3_v;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  fetch_addr,
  input logic           commit_valid,
  input logic           stack_ovf,
  input logic           stack_unf,
  input logic           redirect,
  input logic [AW-1:0]  redir_addr,
  input logic [SPW-1:0] sp
);

  assert_redirect_target_R5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> fetch_addr == $past(redir_addr));

  assert_flush_slot_R5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !commit_valid);

  assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> fetch_addr == $past(fetch_addr) + 1'b1);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    stack_ovf |=> stack_ovf);

  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    stack_unf |=> stack_unf);

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (rst)
    sp <= SPW'(DEPTH));

endmodule

bind useq_sequencer useq_sequencer_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .commit_valid(commit_valid),
  .stack_ovf(stack_ovf), .stack_unf(stack_unf), .redirect(redirect),
  .redir_addr(redir_addr), .sp(stk_sp)
);

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW    = 8;
  localparam int DEPTH = 8;
  localparam int NA    = 1 << AW;

  localparam logic [3:0] JMP_A = 4'b0000, JMP_N = 4'b0001, JMP_S = 4'b0010,
                         JMP_C = 4'b0011, CALL_A = 4'b0100, CALL_N = 4'b0101,
                         CALL_S = 4'b0110, RSUB_A = 4'b1000, RSUB_N = 4'b1001,
                         RSUB_C = 4'b1011, RST_A = 4'b1100, RST_N = 4'b1101;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    ucode_seq;
  logic [AW-1:0] ucode_target;
  logic          dp_flag;
  logic [AW-1:0] fetch_addr, commit_addr;
  logic          commit_valid, stack_ovf, stack_unf;

  logic [3:0]    prog_code [NA];
  logic [AW-1:0] prog_tgt  [NA];
  logic          flag_tbl  [NA];
  logic [AW-1:0] mem_q, mem_q2;

  logic [AW:0]   exp_q[$];
  bit            mon_en = 1'b0;
  int            mon_idx = 0;
  int            mon_checks = 0, mon_errs = 0;
  int            n_checks = 0, n_errs = 0;
  string         cur_req = "R2";
  bit            exp_ovf, exp_unf;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  useq_sequencer #(.AW(AW), .DEPTH(DEPTH)) i_useq_sequencer (
    .clk(clk), .rst(rst), .ucode_seq(ucode_seq), .ucode_target(ucode_target),
    .dp_flag(dp_flag), .fetch_addr(fetch_addr), .commit_addr(commit_addr),
    .commit_valid(commit_valid), .stack_ovf(stack_ovf), .stack_unf(stack_unf)
  );

  // store model: one cycle read latency, flag one cycle after the word
  always @(posedge clk) begin
    mem_q  <= fetch_addr;
    mem_q2 <= mem_q;
  end
  assign ucode_seq    = prog_code[mem_q];
  assign ucode_target = prog_tgt[mem_q];
  assign dp_flag      = flag_tbl[mem_q2];

  // monitor: compares every commit slot against the scoreboard
  always @(negedge clk) begin
    if (!mon_en) begin
      mon_idx = 0;
    end else if (mon_idx < exp_q.size()) begin
      logic [AW:0] e;
      e = exp_q[mon_idx];
      mon_idx++;
      mon_checks++;
      if (commit_valid !== e[AW] || (e[AW] && commit_addr !== e[AW-1:0])) begin
        mon_errs++;
        $display("FAIL %s slot %0d: actual v=%0b a=%0d expected v=%0b a=%0d",
                 cur_req, mon_idx - 1, commit_valid, commit_addr, e[AW], e[AW-1:0]);
      end
    end
  end

  task automatic check(string req, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_prog();
    for (int a = 0; a < NA; a++) begin
      prog_code[a] = JMP_N;
      prog_tgt[a]  = '0;
      flag_tbl[a]  = 1'b0;
    end
  endtask

  // driver: architectural model that queues the expected commit stream
  task automatic build_expected(int n);
    logic [AW-1:0] pc, nxt;
    logic [AW-1:0] stk [DEPTH];
    int            sp, idx;
    bit            ok, taken;
    logic [3:0]    c;
    exp_q.delete();
    repeat (3) exp_q.push_back('0);
    pc = '0; sp = 0; exp_ovf = 0; exp_unf = 0;
    while (exp_q.size() < n) begin
      idx = exp_q.size();
      exp_q.push_back({1'b1, pc});
      c = prog_code[pc];
      case (c[1:0])
        2'd0: ok = 1'b1;
        2'd1: ok = 1'b0;
        2'd2: ok = flag_tbl[pc];
        default: ok = !flag_tbl[pc];
      endcase
      taken = 1'b0;
      nxt = pc + 1'b1;
      if (ok) begin
        case (c[3:2])
          2'd0: begin taken = 1'b1; nxt = prog_tgt[pc]; end
          2'd1: begin
            if (sp == DEPTH) begin
              if (idx <= n - 2) exp_ovf = 1'b1;
            end else begin
              stk[sp] = pc + 1'b1; sp++;
            end
            taken = 1'b1; nxt = prog_tgt[pc];
          end
          2'd2: begin
            if (sp == 0) begin
              if (idx <= n - 2) exp_unf = 1'b1;
            end else begin
              sp--; taken = 1'b1; nxt = stk[sp];
            end
          end
          default: begin sp = 0; taken = 1'b1; nxt = '0; end
        endcase
      end
      if (taken) repeat (3) exp_q.push_back('0);
      pc = nxt;
    end
  endtask

  task automatic run_prog(string req, int n);
    cur_req = req;
    build_expected(n);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mon_en = 1'b1;
    repeat (n) @(negedge clk);
    #1;
    mon_en = 1'b0;
    check(req, "overflow flag", int'(stack_ovf), int'(exp_ovf));
    check(req, "underflow flag", int'(stack_unf), int'(exp_unf));
  endtask

  initial begin
    clear_prog();
    // R1: state while in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "fetch_addr in reset", int'(fetch_addr), 0);
    check("R1", "commit_valid in reset", int'(commit_valid), 0);
    check("R1", "ovf in reset", int'(stack_ovf), 0);
    check("R1", "unf in reset", int'(stack_unf), 0);

    // R2, R10: straight line; failed or "never" conditions do nothing
    clear_prog();
    prog_code[3] = CALL_N; prog_tgt[3] = 8'd90;
    prog_code[4] = RSUB_N;
    prog_code[5] = RST_N;
    prog_code[6] = JMP_S;  prog_tgt[6] = 8'd70;
    prog_code[7] = JMP_C;  prog_tgt[7] = 8'd70; flag_tbl[7] = 1'b1;
    prog_code[8] = CALL_S; prog_tgt[8] = 8'd70;
    prog_code[9] = RSUB_C; flag_tbl[9] = 1'b1;
    run_prog("R10", 40);

    // R3, R4, R5: jumps on flag states
    clear_prog();
    prog_code[2]  = JMP_A; prog_tgt[2]  = 8'd10;
    prog_code[12] = JMP_S; prog_tgt[12] = 8'd30; flag_tbl[12] = 1'b1;
    prog_code[31] = JMP_C; prog_tgt[31] = 8'd5;  flag_tbl[31] = 1'b1;
    prog_code[33] = JMP_C; prog_tgt[33] = 8'd50;
    prog_code[52] = JMP_S; prog_tgt[52] = 8'd0;
    prog_code[55] = JMP_A; prog_tgt[55] = 8'd2;
    run_prog("R4", 60);

    // R6: nested call and return
    clear_prog();
    prog_code[0]  = CALL_A; prog_tgt[0]  = 8'd20;
    prog_code[20] = CALL_A; prog_tgt[20] = 8'd40;
    prog_code[40] = RSUB_A;
    prog_code[21] = RSUB_A;
    prog_code[1]  = CALL_N; prog_tgt[1]  = 8'd99;
    prog_code[2]  = JMP_A;  prog_tgt[2]  = 8'd0;
    run_prog("R6", 70);

    // R5 with R8: taken jump flushes a younger call and return
    clear_prog();
    prog_code[5]  = JMP_A;  prog_tgt[5] = 8'd60;
    prog_code[6]  = CALL_A; prog_tgt[6] = 8'd90;
    prog_code[7]  = RSUB_A;
    prog_code[8]  = CALL_A; prog_tgt[8] = 8'd90;
    prog_code[60] = RSUB_A;
    run_prog("R5", 40);

    // R7: calls past the stack depth
    clear_prog();
    for (int a = 0; a <= DEPTH; a++) begin
      prog_code[a] = CALL_A; prog_tgt[a] = AW'(a + 1);
    end
    prog_code[DEPTH+1] = RSUB_A;
    run_prog("R7", 100);

    // R9: restart empties the stack, so repeated calls never overflow
    clear_prog();
    prog_code[0]  = CALL_A; prog_tgt[0] = 8'd20;
    prog_code[20] = RST_A;
    run_prog("R9", 100);

    // R8, R1: return right after reset underflows
    clear_prog();
    prog_code[0] = RSUB_A;
    run_prog("R8", 14);

    // R1: reset clears the sticky flag
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "unf after reset", int'(stack_unf), 0);
    check("R1", "fetch_addr after reset", int'(fetch_addr), 0);
    check("R1", "commit_valid after reset", int'(commit_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors",
             n_checks + mon_checks, n_errs + mon_errs);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors",
               n_checks + mon_checks + 1, n_errs + mon_errs + 1);
      $finish;
    end
  end

endmodule